// File: doc/BRIEF.md
# GF(2^32) Stream Authentication Tag Engine

This block computes a 32-bit authentication tag over a stream of 32-bit words while the stream is being consumed elsewhere, for example by a counter-mode decryptor working on a configuration image. Each accepted word is folded into a 32-bit accumulator by an XOR followed by a multiplication in GF(2^32). The multiplication uses a hash key that is captured when a message opens. The reduction polynomial is built into the hardware and cannot be changed from outside.

A message opens with a start pulse. Words then arrive on a valid/ready handshake, and the block absorbs one word in every clock in which a word is offered. When the word flagged as last has been taken, the block spends exactly one cycle absorbing a length block, which is the number of accepted words. It then XORs the result with a mask to form the tag, and compares the tag with an expected value. The tag, a done flag and a pass flag are held until the next start. The block does not derive the key and does not decrypt anything.

Reset is asynchronous and active low. Its release is resynchronised inside the block, so the block is ready two rising edges after `rst_n` goes high.

Top module: `gf32_tag_accum`

## Requirements
- R1: After reset, `in_ready_o` is 1, `tag_done_o` is 0, `tag_pass_o` is 0 and `tag_o` is 0.
- R2: A start pulse clears the accumulator, the word count, `tag_o`, `tag_done_o` and `tag_pass_o`, and captures `hkey_i` as H. Changes on `hkey_i` after that edge do not affect the message.
- R3: While a message is open and the length block is not being absorbed, `in_ready_o` stays 1. A word offered in every cycle is therefore accepted in every cycle, with no stall.
- R4: Each accepted word w updates the accumulator as acc = (acc XOR w) * H, reduced modulo P(x) = x^32 + x^22 + x^2 + x + 1. Bit i of a value is the coefficient of x^i. For example, with H = 1 the accumulator after one word w equals w.
- R5: In the cycle after the last word is accepted, the count of accepted words (modulo 2^32) is absorbed as one more word. On the next edge `tag_o` becomes the accumulator XOR `mask_i`, and `tag_done_o` rises. `mask_i` is sampled in that absorb cycle.
- R6: `in_ready_o` is 0 only in the single cycle that follows acceptance of the last word, and is 1 again in the cycle after that.
- R7: `tag_pass_o` is 1 exactly when the computed tag equals `exp_tag_i` as sampled in the absorb cycle. `tag_o`, `tag_pass_o` and `tag_done_o` are held until the next start.
- R8: Words offered while no message is open are ignored. This covers words offered before the first start and words offered after the tag is done: they leave `tag_o`, `tag_done_o` and `tag_pass_o` unchanged and start no length absorption.
- R9: Start has priority. A word offered in the same cycle as the start pulse is not absorbed, even if it is flagged as last.
- R10: Cycles with `in_valid_i` low inside a message do not change the accumulator or the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new message and captures the key |
| hkey_i | input | 32 | Hash key H |
| mask_i | input | 32 | Mask XORed into the final accumulator |
| exp_tag_i | input | 32 | Expected tag for the comparison |
| in_valid_i | input | 1 | Data word offered |
| in_ready_o | output | 1 | Block can take a word |
| in_data_i | input | 32 | Data word |
| in_last_i | input | 1 | Offered word is the final one of the message |
| tag_o | output | 32 | Computed tag |
| tag_done_o | output | 1 | Tag and pass flag are valid |
| tag_pass_o | output | 1 | Computed tag matches the expected tag |

## Verification
The assertions assume that `start_i` is a pulse driven synchronously to the clock. They also assume that `mask_i` and `exp_tag_i` are stable by the cycle in which the length block is absorbed. The bench drives every input on the falling edge and holds mask and expected tag from the moment the last word is offered. It raises start only as a separate step, or together with one deliberately offered word for the priority case. Stray words are offered only outside an open message, so that the hold properties on tag and flags are tested against real stimulus.

// File: rtl/gf32_tag_pkg.sv
package gf32_tag_pkg;

  localparam int unsigned GF_W    = 32;
  localparam int unsigned PROD_W  = 2 * GF_W - 1;
  // low terms of x^32 + x^22 + x^2 + x + 1
  localparam logic [GF_W-1:0] GF_POLY_LOW = 32'h0040_0007;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2,
    ST_DONE  = 2'd3
  } tag_state_e;

  function automatic logic [GF_W-1:0] gf_reduce(input logic [PROD_W-1:0] prod);
    logic [PROD_W-1:0] t;
    logic [PROD_W-1:0] fold;
    t = prod;
    for (int i = PROD_W - 1; i >= GF_W; i--) begin
      if (t[i]) begin
        fold = {{(PROD_W-GF_W){1'b0}}, GF_POLY_LOW} << (i - GF_W);
        fold[i] = 1'b1;
        t = t ^ fold;
      end
    end
    return t[GF_W-1:0];
  endfunction

endpackage

// File: rtl/gf32_mult.sv
module gf32_mult
  import gf32_tag_pkg::*;
(
  input  logic [GF_W-1:0] a_i,
  input  logic [GF_W-1:0] b_i,
  output logic [GF_W-1:0] p_o
);

  logic [PROD_W-1:0] part [GF_W];
  logic [PROD_W-1:0] clmul;

  genvar g;
  generate
    for (g = 0; g < GF_W; g++) begin : g_part
      assign part[g] = b_i[g] ? ({{(PROD_W-GF_W){1'b0}}, a_i} << g) : '0;
    end
  endgenerate

  always_comb begin
    clmul = '0;
    for (int i = 0; i < GF_W; i++) begin
      clmul = clmul ^ part[i];
    end
  end

  assign p_o = gf_reduce(clmul);

endmodule

// File: rtl/tag_fsm.sv
module tag_fsm
  import gf32_tag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic in_valid_i,
  input  logic in_last_i,
  output logic in_ready_o,
  output logic accept_o,
  output logic finalize_o
);

  tag_state_e state_q;
  tag_state_e state_d;

  assign in_ready_o = (state_q != ST_FINAL);
  assign accept_o   = in_valid_i && (state_q == ST_RUN) && !start_i;
  assign finalize_o = (state_q == ST_FINAL) && !start_i;

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN:   if (accept_o && in_last_i) state_d = ST_FINAL;
        ST_FINAL: state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/tag_accum_core.sv
module tag_accum_core
  import gf32_tag_pkg::*;
#(
  parameter int unsigned CNT_W = GF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [GF_W-1:0] hkey_i,
  input  logic            accept_i,
  input  logic            finalize_i,
  input  logic [GF_W-1:0] word_i,
  input  logic [GF_W-1:0] mask_i,
  input  logic [GF_W-1:0] exp_tag_i,
  output logic [GF_W-1:0] tag_o,
  output logic            done_o,
  output logic            pass_o
);

  logic [GF_W-1:0]  acc_q, acc_d;
  logic [GF_W-1:0]  key_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GF_W-1:0]  tag_d;
  logic             done_d, pass_d;
  logic             acc_en, key_en, cnt_en, res_en;
  logic [GF_W-1:0]  len_blk;
  logic [GF_W-1:0]  mul_a;
  logic [GF_W-1:0]  mul_p;
  logic [GF_W-1:0]  fin_tag;

  generate
    if (CNT_W >= GF_W) begin : g_len_trunc
      assign len_blk = cnt_q[GF_W-1:0];
    end else begin : g_len_pad
      assign len_blk = {{(GF_W-CNT_W){1'b0}}, cnt_q};
    end
  endgenerate

  assign mul_a   = finalize_i ? (acc_q ^ len_blk) : (acc_q ^ word_i);
  assign fin_tag = mul_p ^ mask_i;

  gf32_mult mult_i (
    .a_i (mul_a),
    .b_i (key_q),
    .p_o (mul_p)
  );

  always_comb begin
    acc_en = start_i || accept_i || finalize_i;
    key_en = start_i;
    cnt_en = start_i || accept_i;
    res_en = start_i || finalize_i;
    acc_d  = start_i ? '0 : mul_p;
    cnt_d  = start_i ? '0 : cnt_q + 1'b1;
    tag_d  = start_i ? '0 : fin_tag;
    done_d = !start_i;
    pass_d = !start_i && (fin_tag == exp_tag_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      key_q  <= '0;
      cnt_q  <= '0;
      tag_o  <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (key_en) key_q <= hkey_i;
      if (cnt_en) cnt_q <= cnt_d;
      if (res_en) begin
        tag_o  <= tag_d;
        done_o <= done_d;
        pass_o <= pass_d;
      end
    end
  end

endmodule

// File: rtl/gf32_tag_accum.sv
module gf32_tag_accum
  import gf32_tag_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] hkey_i,
  input  logic [31:0] mask_i,
  input  logic [31:0] exp_tag_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [31:0] in_data_i,
  input  logic        in_last_i,
  output logic [31:0] tag_o,
  output logic        tag_done_o,
  output logic        tag_pass_o
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       accept;
  logic       finalize;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  tag_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .in_ready_o (in_ready_o),
    .accept_o   (accept),
    .finalize_o (finalize)
  );

  tag_accum_core #(
    .CNT_W (CNT_W)
  ) core_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .hkey_i     (hkey_i),
    .accept_i   (accept),
    .finalize_i (finalize),
    .word_i     (in_data_i),
    .mask_i     (mask_i),
    .exp_tag_i  (exp_tag_i),
    .tag_o      (tag_o),
    .done_o     (tag_done_o),
    .pass_o     (tag_pass_o)
  );

endmodule

// File: rtl/gf32_tag_accum_chk.sv
module gf32_tag_accum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        in_last_i,
  input logic        run_active,
  input logic        tag_done_o,
  input logic        tag_pass_o,
  input logic [31:0] tag_o
);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!tag_done_o && !tag_pass_o && tag_o == 32'h0));

  assert_ready_single_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready_o |=> in_ready_o);

  assert_last_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && in_last_i && run_active && !start_i) |=> !in_ready_o);

  assert_done_follows_absorb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready_o && !start_i) |=> tag_done_o);

  assert_pass_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_pass_o |-> tag_done_o);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_done_o && !start_i) |=> (tag_done_o && $stable(tag_o) && $stable(tag_pass_o)));

  assert_open_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && !start_i && !(in_valid_i && in_last_i)) |=> in_ready_o);

endmodule

bind gf32_tag_accum gf32_tag_accum_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_i    (start_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_last_i  (in_last_i),
  .run_active (fsm_i.state_q == gf32_tag_pkg::ST_RUN),
  .tag_done_o (tag_done_o),
  .tag_pass_o (tag_pass_o),
  .tag_o      (tag_o)
);

// File: tb/gf32_tag_accum_tb_top.sv
module gf32_tag_accum_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] hkey_i, mask_i, exp_tag_i, in_data_i;
  logic        in_valid_i, in_last_i;
  logic        in_ready_o, tag_done_o, tag_pass_o;
  logic [31:0] tag_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_tag_q[$];
  logic        exp_pass_q[$];

  logic [31:0] m_acc, m_key, m_cnt;
  logic        done_prev = 1'b0;

  always #10 clk = ~clk;

  gf32_tag_accum dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hkey_i(hkey_i),
    .mask_i(mask_i), .exp_tag_i(exp_tag_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .tag_o(tag_o), .tag_done_o(tag_done_o), .tag_pass_o(tag_pass_o)
  );

  function automatic logic [31:0] xt(input logic [31:0] v);
    return v[31] ? ((v << 1) ^ 32'h0040_0007) : (v << 1);
  endfunction

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    for (int i = 31; i >= 0; i--) begin
      r = xt(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a tag completes
  always @(negedge clk) begin
    if (tag_done_o && !done_prev) begin
      if (exp_tag_q.size() == 0) begin
        check(1'b0, "R5 unexpected tag", tag_o, 32'h0);
      end else begin
        logic [31:0] et;
        logic        ep;
        et = exp_tag_q.pop_front();
        ep = exp_pass_q.pop_front();
        check(tag_o == et, "R4/R5 tag", tag_o, et);
        check(tag_pass_o == ep, "R7 pass", {31'b0, tag_pass_o}, {31'b0, ep});
      end
    end
    done_prev = tag_done_o;
  end

  task automatic begin_msg(input logic [31:0] h, input bit with_word);
    @(negedge clk);
    start_i = 1'b1; hkey_i = h;
    in_valid_i = with_word; in_last_i = with_word; in_data_i = 32'hDEAD_BEEF;
    @(negedge clk);
    start_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
    hkey_i = ~h;
    m_acc = '0; m_key = h; m_cnt = '0;
    check(tag_o == 32'h0 && !tag_done_o && !tag_pass_o, "R2 start clears", tag_o, 32'h0);
    check(in_ready_o == 1'b1, "R9 start-word not absorbed", {31'b0, in_ready_o}, 32'h1);
  endtask

  task automatic push_word(input logic [31:0] w, input bit last, input int gap,
                           input bit want_pass, input logic [31:0] mask);
    logic [31:0] t;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      in_valid_i = 1'b0; in_data_i = ~w;
    end
    @(negedge clk);
    check(in_ready_o == 1'b1, "R3 no stall", {31'b0, in_ready_o}, 32'h1);
    in_valid_i = 1'b1; in_data_i = w; in_last_i = last;
    m_acc = ref_mul(m_acc ^ w, m_key);
    m_cnt = m_cnt + 1;
    if (last) begin
      t = ref_mul(m_acc ^ m_cnt, m_key) ^ mask;
      mask_i = mask;
      exp_tag_i = want_pass ? t : (t ^ 32'h0000_0100);
      exp_tag_q.push_back(t);
      exp_pass_q.push_back(want_pass);
    end
    @(posedge clk);
  endtask

  task automatic end_msg();
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0;
    check(in_ready_o == 1'b0, "R6 ready low in absorb cycle", {31'b0, in_ready_o}, 32'h0);
    @(negedge clk);
    check(in_ready_o == 1'b1, "R6 ready back", {31'b0, in_ready_o}, 32'h1);
    check(tag_done_o == 1'b1, "R5 done", {31'b0, tag_done_o}, 32'h1);
  endtask

  task automatic stray(input int n);
    logic [31:0] t0;
    logic        d0, p0;
    t0 = tag_o; d0 = tag_done_o; p0 = tag_pass_o;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid_i = 1'b1; in_last_i = 1'b1; in_data_i = 32'h5A5A_0000 + k;
    end
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0;
    @(negedge clk);
    check(tag_o == t0, "R8 tag untouched", tag_o, t0);
    check(tag_done_o == d0 && tag_pass_o == p0, "R8 flags untouched",
          {30'b0, tag_done_o, tag_pass_o}, {30'b0, d0, p0});
    check(in_ready_o == 1'b1, "R8 no absorb started", {31'b0, in_ready_o}, 32'h1);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; hkey_i = '0; mask_i = '0; exp_tag_i = '0;
    in_valid_i = 1'b0; in_last_i = 1'b0; in_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready_o && !tag_done_o && !tag_pass_o && tag_o == 0, "R1 reset state",
          {tag_o[31:3], in_ready_o, tag_done_o, tag_pass_o}, 32'h4);

    // R8: words before any start
    stray(3);

    // R4: H = 1, one word -> tag = w ^ count(1)
    begin_msg(32'h0000_0001, 1'b0);
    push_word(32'h1234_5678, 1'b1, 0, 1'b1, 32'h0);
    end_msg();
    check(tag_o == 32'h1234_5679, "R4 hand value H=1", tag_o, 32'h1234_5679);

    // R3: 16 back-to-back words, pass expected
    begin_msg(32'h9E37_79B9, 1'b0);
    for (int i = 0; i < 16; i++)
      push_word(32'h0100_0000 * i + 32'hC3 ^ (i * 32'h0001_1111), i == 15, 0, 1'b1, 32'hA5A5_5A5A);
    end_msg();

    // R10/R7: gapped message with a mismatching expected tag
    begin_msg(32'h8000_0003, 1'b0);
    for (int i = 0; i < 7; i++)
      push_word(32'hFFFF_0000 ^ (i * 32'h0F0F_0F0F), i == 6, i % 3, 1'b0, 32'h1357_9BDF);
    end_msg();
    check(tag_pass_o == 1'b0, "R7 mismatch clears pass", {31'b0, tag_pass_o}, 32'h0);

    // R8: words after done are ignored
    stray(4);

    // R9: start with a last-flagged word; then a 3-word message
    begin_msg(32'h0040_0007, 1'b1);
    push_word(32'hFFFF_FFFF, 1'b0, 0, 1'b1, 32'h0);
    push_word(32'h8000_0000, 1'b0, 1, 1'b1, 32'h0);
    push_word(32'h0000_0001, 1'b1, 0, 1'b1, 32'h0);
    end_msg();

    // R4 boundary: H = 0 -> tag = mask
    begin_msg(32'h0000_0000, 1'b0);
    push_word(32'hCAFE_F00D, 1'b0, 0, 1'b1, 32'h6666_1111);
    push_word(32'h0BAD_C0DE, 1'b1, 0, 1'b1, 32'h6666_1111);
    end_msg();
    check(tag_o == 32'h6666_1111, "R4 zero key", tag_o, 32'h6666_1111);

    repeat (2) @(negedge clk);
    check(exp_tag_q.size() == 0, "R5 every tag produced", exp_tag_q.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule